// File: doc/BRIEF.md
# Character Display Raster Timing Generator

This block produces every raster and character timing signal for a character display of 40 columns by 13 text rows, all from one master clock of about 1.1667 MHz. Each stage of a chain of fixed-ratio countdowns runs on a single-cycle clock enable from the stage before it, and every register shares the master clock. Two divide-by-2 stages give a fast minor vertical deflection gate, a half-rate gate and four phase enables. A divide-by-7 stage, which advances only in phase 2, sets the character time. A divide-by-4 stage and a divide-by-11 stage together count 44 character slots per line: 40 visible slots and 4 slots of horizontal retrace. A divide-by-14 stage counts 14 lines per frame: 13 visible rows and one line of vertical retrace.

The column and row indices are outputs, so a downstream video path can look up the character under the beam. The block issues strobes at the start of each character, each line and each frame, and raises flags during both retraces. A second, separate divider of the master clock produces a key auto-repeat pulse and a cursor blink level that changes on every second repeat pulse.

Top module: `crt_timing_gen`

## Requirements
- R1: A synchronous reset, with `rst` high at a rising edge, clears every stage. In the first cycle after reset, `phase_en` is 4'b0001, `col_idx`, `row_idx` and `blink` are 0, and no strobe is active.
- R2: A 2-bit phase count advances once per master clock. `phase_en` is one-hot, with bit i set while the count equals i, so the order is 0,1,2,3,0. `minor_gate` equals bit 0 of the count and `slow_gate` equals bit 1.
- R3: `char_stb` is high for one cycle in every 28 master clocks, always in a cycle where `phase_en[2]` is set. This is 7 phase-2 cycles per character.
- R4: `col_idx` steps from 0 to 43 once per character time and then wraps to 0. It changes only at the edge that closes the seventh phase-2 cycle of a character. `hretrace` is high exactly when `col_idx` is 40 or more.
- R5: `line_stb` is high only together with `char_stb` while `col_idx` is 0. This gives one strobe per 44 characters (1232 clocks).
- R6: `row_idx` steps from 0 to 13 once per line and then wraps to 0. `vretrace` is high exactly when `row_idx` is 13. `frame_stb` is high only together with `line_stb` while `row_idx` is 0, which gives a period of 17248 clocks.
- R7: The first `char_stb` after reset comes in cycle 2, counted from 0 as the first cycle after reset, with `col_idx`=0 and `row_idx`=0.
- R8: `repeat_pulse` is high for one cycle in every REP_DIV master clocks, in cycles n where n mod REP_DIV equals REP_DIV-1.
- R9: `blink` changes state on every second `repeat_pulse`. The blink toggle rate is therefore half the repeat rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| minor_gate | output | 1 | Master clock divided by 2 (minor vertical deflection) |
| slow_gate | output | 1 | Master clock divided by 4 |
| phase_en | output | 4 | One-hot phase enables |
| char_stb | output | 1 | Start of a character slot |
| line_stb | output | 1 | Start of a line |
| frame_stb | output | 1 | Start of a frame |
| hretrace | output | 1 | Horizontal retrace slot |
| vretrace | output | 1 | Vertical retrace line |
| col_idx | output | 6 | Character column, 0 to 43 |
| row_idx | output | 4 | Text row, 0 to 13 |
| repeat_pulse | output | 1 | Auto-repeat tick |
| blink | output | 1 | Cursor blink level |

## Verification
The bench compares every output in every cycle with values it computes from the cycle number since reset. It sweeps two full frames, which covers each column and row wrap, each retrace boundary and each strobe coincidence. A second reset arrives in the middle of a frame, which shows that every stage returns to its start state and not just the phase count. A short repeat divider gives many repeat pulses and blink transitions in the same run, so that toggling on every pulse can be told apart from toggling on every second pulse.

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int CHAR_DIV    = 7,
  parameter int GROUP_CHARS = 4,
  parameter int LINE_GROUPS = 11,
  parameter int VIS_COLS    = 40,
  parameter int FRAME_LINES = 14,
  parameter int VIS_ROWS    = 13,
  parameter int REP_DIV     = 194450,
  localparam int COLS  = GROUP_CHARS * LINE_GROUPS,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(FRAME_LINES),
  localparam int CH_W  = $clog2(CHAR_DIV),
  localparam int GL_W  = $clog2(GROUP_CHARS),
  localparam int GH_W  = $clog2(LINE_GROUPS),
  localparam int REP_W = $clog2(REP_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             minor_gate,
  output logic             slow_gate,
  output logic [3:0]       phase_en,
  output logic             char_stb,
  output logic             line_stb,
  output logic             frame_stb,
  output logic             hretrace,
  output logic             vretrace,
  output logic [COL_W-1:0] col_idx,
  output logic [ROW_W-1:0] row_idx,
  output logic             repeat_pulse,
  output logic             blink
);

  logic [1:0]       ph;
  logic [CH_W-1:0]  ch_cnt;
  logic [GL_W-1:0]  grp_lo;
  logic [GH_W-1:0]  grp_hi;
  logic [ROW_W-1:0] row;
  logic [REP_W-1:0] rep_cnt;
  logic             rep_half;
  logic             blink_q;

  logic ph2, ch_last, lo_last, hi_last, row_last, rep_last;

  assign ph2      = (ph == 2'd2);
  assign ch_last  = ph2 && (ch_cnt == CH_W'(CHAR_DIV - 1));
  assign lo_last  = (grp_lo == GL_W'(GROUP_CHARS - 1));
  assign hi_last  = (grp_hi == GH_W'(LINE_GROUPS - 1));
  assign row_last = (row == ROW_W'(FRAME_LINES - 1));
  assign rep_last = (rep_cnt == REP_W'(REP_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      ch_cnt <= '0;
      grp_lo <= '0;
      grp_hi <= '0;
      row    <= '0;
    end else begin
      ph <= ph + 2'd1;
      if (ph2)
        ch_cnt <= ch_last ? '0 : ch_cnt + 1'b1;
      if (ch_last) begin
        grp_lo <= lo_last ? '0 : grp_lo + 1'b1;
        if (lo_last) begin
          grp_hi <= hi_last ? '0 : grp_hi + 1'b1;
          if (hi_last)
            row <= row_last ? '0 : row + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_cnt  <= '0;
      rep_half <= 1'b0;
      blink_q  <= 1'b0;
    end else begin
      rep_cnt <= rep_last ? '0 : rep_cnt + 1'b1;
      if (rep_last) begin
        rep_half <= ~rep_half;
        if (rep_half)
          blink_q <= ~blink_q;
      end
    end
  end

  assign minor_gate   = ph[0];
  assign slow_gate    = ph[1];
  assign phase_en     = 4'b0001 << ph;
  assign col_idx      = COL_W'(grp_hi) * COL_W'(GROUP_CHARS) + COL_W'(grp_lo);
  assign row_idx      = row;
  assign char_stb     = ph2 && (ch_cnt == '0);
  assign line_stb     = char_stb && (col_idx == '0);
  assign frame_stb    = line_stb && (row == '0);
  assign hretrace     = (col_idx >= COL_W'(VIS_COLS));
  assign vretrace     = (row >= ROW_W'(VIS_ROWS));
  assign repeat_pulse = rep_last;
  assign blink        = blink_q;

endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk #(
  parameter int COL_W = 6,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       phase_en,
  input logic             char_stb,
  input logic             line_stb,
  input logic             frame_stb,
  input logic [COL_W-1:0] col_idx,
  input logic [ROW_W-1:0] row_idx,
  input logic             repeat_pulse,
  input logic             blink
);

  a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_en) == 1);

  a_r2_phase_wraps: assert property (@(posedge clk) disable iff (rst)
    phase_en[3] |=> phase_en[0]);

  a_r3_char_in_phase2: assert property (@(posedge clk) disable iff (rst)
    char_stb |-> phase_en[2]);

  a_r4_col_moves_after_phase2: assert property (@(posedge clk) disable iff (rst)
    !$stable(col_idx) |-> $past(phase_en[2]));

  a_r5_line_at_col0: assert property (@(posedge clk) disable iff (rst)
    line_stb |-> (char_stb && col_idx == '0));

  a_r6_frame_at_row0: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> (line_stb && row_idx == '0));

  a_r9_blink_on_repeat: assert property (@(posedge clk) disable iff (rst)
    !$stable(blink) |-> $past(repeat_pulse));

endmodule

bind crt_timing_gen crt_timing_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .phase_en(phase_en), .char_stb(char_stb),
  .line_stb(line_stb), .frame_stb(frame_stb), .col_idx(col_idx),
  .row_idx(row_idx), .repeat_pulse(repeat_pulse), .blink(blink)
);

// File: tb/crt_timing_gen_tb.sv
`timescale 1ns/1ps
module crt_timing_gen_tb;
  localparam int CD = 7;
  localparam int COLS = 44;
  localparam int FL = 14;
  localparam int RD = 50;
  localparam int FRAME = 4 * CD * COLS * FL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic minor_gate, slow_gate, char_stb, line_stb, frame_stb;
  logic hretrace, vretrace, repeat_pulse, blink;
  logic [3:0] phase_en;
  logic [5:0] col_idx;
  logic [3:0] row_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  crt_timing_gen #(.REP_DIV(RD)) u_dut (
    .clk(clk), .rst(rst), .minor_gate(minor_gate), .slow_gate(slow_gate),
    .phase_en(phase_en), .char_stb(char_stb), .line_stb(line_stb),
    .frame_stb(frame_stb), .hretrace(hretrace), .vretrace(vretrace),
    .col_idx(col_idx), .row_idx(row_idx), .repeat_pulse(repeat_pulse),
    .blink(blink)
  );

  task automatic chk(input string req, input string what, input int act, input int exp, input int cyc);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: got %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sweep(input int cycles);
    int first_ch;
    first_ch = -1;
    for (int n = 0; n < cycles; n++) begin
      int k, col, row, p;
      logic ch;
      k   = (n + 1) / 4;
      ch  = (n % 4 == 2) && (k % CD == 0);
      col = (k / CD) % COLS;
      row = (k / (CD * COLS)) % FL;
      p   = n / RD;
      if (n == 0) begin
        chk("R1", "phase_en", int'(phase_en), 1, n);
        chk("R1", "col_idx", int'(col_idx), 0, n);
        chk("R1", "row_idx", int'(row_idx), 0, n);
        chk("R1", "blink", int'(blink), 0, n);
        chk("R1", "char_stb", int'(char_stb), 0, n);
      end
      chk("R2", "phase_en", int'(phase_en), 1 << (n % 4), n);
      chk("R2", "minor_gate", int'(minor_gate), n % 2, n);
      chk("R2", "slow_gate", int'(slow_gate), (n / 2) % 2, n);
      chk("R3", "char_stb", int'(char_stb), int'(ch), n);
      chk("R4", "col_idx", int'(col_idx), col, n);
      chk("R4", "hretrace", int'(hretrace), int'(col >= 40), n);
      chk("R5", "line_stb", int'(line_stb), int'(ch && col == 0), n);
      chk("R6", "row_idx", int'(row_idx), row, n);
      chk("R6", "vretrace", int'(vretrace), int'(row == 13), n);
      chk("R6", "frame_stb", int'(frame_stb), int'(ch && col == 0 && row == 0), n);
      chk("R8", "repeat_pulse", int'(repeat_pulse), int'(n % RD == RD - 1), n);
      chk("R9", "blink", int'(blink), (p / 2) % 2, n);
      if (char_stb && first_ch < 0) begin
        first_ch = n;
        chk("R7", "first col", int'(col_idx), 0, n);
        chk("R7", "first row", int'(row_idx), 0, n);
      end
      @(negedge clk);
    end
    chk("R7", "first char_stb cycle", first_ch, 2, 0);
  endtask

  initial begin
    #(190000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    sweep(2 * FRAME + 200);
    // mid-frame reset: every stage must restart (R1)
    repeat (5000) @(negedge clk);
    do_reset();
    sweep(8000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule